// File: doc/BRIEF.md
# Prescaled Reference Compare Timer

A 16-bit timer that counts prescaled ticks of the system clock and flags an event when the count meets a programmed reference value. Software sets it up through a small register port. It writes a packed mode word, a reference value, a capture word and the count itself. It reads back all of these and an event register whose flags clear when a one is written to them. The timer has a single level-sensitive interrupt output.

The mode word holds the prescale value, the clock source, the restart-on-reference choice and the interrupt enable. It also holds output-mode and capture-edge bits, which are stored and read back but drive no logic. The register port is plain control: a write is accepted in the cycle that `wr_en` is high, so there is no back-pressure. Read data is a combinational function of `addr` and the current register state.

Top module: `tmr_ref_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Byte offsets are decoded as follows: 0x00 is mode, 0x04 is reference, 0x08 is capture, 0x0C is count and 0x11 is event. Other offsets read zero and ignore writes. The capture register stores and returns what is written to it.
- R3: Mode bits are placed as follows: bit 0 is enable, bits 2:1 are clock source, bit 3 is restart on reference, bit 4 is interrupt enable and bits 15:8 are prescale P. With source 1, the counter advances once every P+1 clocks.
- R4: With source 2, the counter advances once every (P+1)*16 clocks.
- R5: With source 0 or 3, the counter does not advance even while enabled.
- R6: On a tick where the count equals the reference, event bit 1 is set. If mode bit 3 is set the count returns to zero; otherwise it goes on to count+1, wrapping modulo 2^16.
- R7: `irq` is high exactly when mode bit 4 and event bit 1 are both set.
- R8: Writing ones to the event register clears the matching bits (bit 0 capture, bit 1 reference). A reference hit in the same cycle as a clear leaves bit 1 set.
- R9: A mode write that changes bit 0 from 1 to 0 also clears the reference register. A mode write that leaves bit 0 set keeps the reference.
- R10: While mode bit 0 is clear, the counter and prescaler stay at zero, writes to the count are ignored and no events are set.
- R11: While enabled, a write to the count loads the written value, and that cycle produces no hit.
- R12: A write to mode or reference zeroes the counter and the prescaler, and that cycle produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Reference interrupt level |

## Verification
The hardest case to reach from the ports is a reference hit that falls in the same cycle as a software clear of the reference flag, because hits are normally spaced many cycles apart. The bench sets the reference to zero with restart enabled and a divide of one, so a hit occurs on every clock. It then issues the clear and checks that the flag stays set. A random phase of short mode, reference, count and clear writes runs against the cycle model to cover collisions of restart, load and tick.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  // mode word bit positions
  localparam int MB_EN     = 0;
  localparam int MB_SRC_LO = 1;
  localparam int MB_WRAP   = 3;
  localparam int MB_IEN    = 4;
  localparam int MB_PS_LO  = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

  typedef enum logic [1:0] {
    SRC_IDLE_A = 2'd0,
    SRC_SYS    = 2'd1,
    SRC_SLOW   = 2'd2,
    SRC_IDLE_B = 2'd3
  } tmr_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16,
  localparam int SLOW_SH = $clog2(SLOW_DIV),
  localparam int PC_W    = PS_W + SLOW_SH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            slow,
  input  logic [PS_W-1:0] ps_val,
  output logic            tick,
  output logic [PC_W-1:0] pcnt
);
  logic [PC_W-1:0] limit;

  // terminal value is ratio-1: P, or P*SLOW_DIV + SLOW_DIV-1
  assign limit = slow ? {ps_val, {SLOW_SH{1'b1}}} : PC_W'(ps_val);
  assign tick  = run && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!run || restart || tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             wrap,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic at_ref;

  assign at_ref = (cnt == ref_val);
  assign hit    = en && tick && at_ref && !restart && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || restart) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      if (at_ref && wrap) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] mode_q,
  output logic [CNT_W-1:0]  ref_q,
  output logic [1:0]        evt_q,
  output logic              restart,
  output logic              load,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] cap_q;
  logic [1:0]        evt_clr;

  assign restart = wr_en && (addr == OFS_MODE || addr == OFS_REF);
  assign load    = wr_en && (addr == OFS_CNT);
  assign evt_clr = (wr_en && addr == OFS_EVT) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      evt_q  <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          OFS_MODE: begin
            mode_q <= wdata;
            if (mode_q[MB_EN] && !wdata[MB_EN]) ref_q <= '0;
          end
          OFS_REF: ref_q <= wdata[CNT_W-1:0];
          OFS_CAP: cap_q <= wdata;
          default: ;
        endcase
      end
      evt_q <= (evt_q & ~evt_clr) | {hit, 1'b0};
    end
  end

  always_comb begin
    case (addr)
      OFS_MODE: rdata = mode_q;
      OFS_REF:  rdata = DATA_W'(ref_q);
      OFS_CAP:  rdata = cap_q;
      OFS_CNT:  rdata = DATA_W'(cnt);
      OFS_EVT:  rdata = DATA_W'(evt_q);
      default:  rdata = '0;
    endcase
  end

  assign irq = mode_q[MB_IEN] & evt_q[1];
endmodule

// File: rtl/tmr_ref_timer.sv
`timescale 1ns/1ps
module tmr_ref_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 8,
  parameter int SLOW_DIV = 16,
  localparam int PC_W    = PS_W + $clog2(SLOW_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] mode_q;
  logic [CNT_W-1:0]  ref_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        evt_q;
  logic [PC_W-1:0]   pcnt_q;
  logic              restart, load, tick, hit;
  logic              en, run, slow;
  tmr_src_e          src;

  assign en   = mode_q[MB_EN];
  assign src  = tmr_src_e'(mode_q[MB_SRC_LO +: 2]);
  assign slow = (src == SRC_SLOW);
  assign run  = en && (src == SRC_SYS || src == SRC_SLOW);

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(hit), .cnt(cnt_q), .mode_q(mode_q), .ref_q(ref_q), .evt_q(evt_q),
    .restart(restart), .load(load), .rdata(rdata), .irq(irq)
  );

  tmr_prescaler #(.PS_W(PS_W), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .slow(slow),
    .ps_val(mode_q[MB_PS_LO +: PS_W]), .tick(tick), .pcnt(pcnt_q)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .load(load),
    .load_val(wdata[CNT_W-1:0]), .tick(tick), .ref_val(ref_q),
    .wrap(mode_q[MB_WRAP]), .cnt(cnt_q), .hit(hit)
  );
endmodule

// File: rtl/tmr_ref_timer_chk.sv
`timescale 1ns/1ps
module tmr_ref_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PC_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic [15:0]      wdata,
  input logic             irq,
  input logic             en,
  input logic [1:0]       src_bits,
  input logic             ien,
  input logic [CNT_W-1:0] ref_q,
  input logic             evt_ref,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PC_W-1:0]  pcnt_q,
  input logic             tick,
  input logic             hit
);
  // R7
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_ref && ien));
  // R6
  a_r6_hit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_ref);
  // R8
  a_r8_clear_wins_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h11 && wdata[1] && !hit) |=> !evt_ref);
  // R10
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt_q == '0 && pcnt_q == '0));
  // R5
  a_r5_no_tick_src: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (src_bits == 2'd0 || src_bits == 2'd3)) |-> !tick);
  // R9
  a_r9_disable_clears_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h00 && en && !wdata[0]) |=> ref_q == '0);
  // R12
  a_r12_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 5'h00 || addr == 5'h04)) |=> (cnt_q == '0 && pcnt_q == '0));
  // R11
  a_r11_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h0C && en) |=> cnt_q == $past(wdata[CNT_W-1:0]));
endmodule

bind tmr_ref_timer tmr_ref_timer_chk #(.CNT_W(CNT_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .en(mode_q[0]), .src_bits(mode_q[2:1]), .ien(mode_q[4]),
  .ref_q(ref_q), .evt_ref(evt_q[1]), .cnt_q(cnt_q), .pcnt_q(pcnt_q),
  .tick(tick), .hit(hit)
);

// File: tb/tmr_ref_timer_tb.sv
`timescale 1ns/1ps
module tmr_ref_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'h00;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_mode = 0, m_ref = 0, m_cap = 0, m_evt = 0, m_cnt = 0, m_pre = 0;

  always #5 clk = ~clk;

  tmr_ref_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      'h00: return m_mode;
      'h04: return m_ref;
      'h08: return m_cap;
      'h0C: return m_cnt;
      'h11: return m_evt;
      default: return 0;
    endcase
  endfunction

  // cycle model, updated at every active edge
  always @(posedge clk) begin
    int ratio, src, nxt_cnt, nxt_pre, clr;
    bit on, counting, tk, hit, rs;
    if (!rst_n) begin
      m_mode = 0; m_ref = 0; m_cap = 0; m_evt = 0; m_cnt = 0; m_pre = 0;
    end else begin
      on = (m_mode & 1) != 0;
      src = (m_mode >> 1) & 3;
      ratio = ((m_mode >> 8) + 1) * ((src == 2) ? 16 : 1);
      counting = on && (src == 1 || src == 2);
      tk = counting && (m_pre == ratio - 1);
      rs = wr_en && (addr == 5'h00 || addr == 5'h04);
      hit = 1'b0;
      if (!on || rs) nxt_cnt = 0;
      else if (wr_en && addr == 5'h0C) nxt_cnt = wdata;
      else if (tk) begin
        if (m_cnt == m_ref) begin
          hit = 1'b1;
          nxt_cnt = ((m_mode & 8) != 0) ? 0 : ((m_cnt + 1) & 'hFFFF);
        end else nxt_cnt = (m_cnt + 1) & 'hFFFF;
      end else nxt_cnt = m_cnt;
      nxt_pre = (!counting || rs || tk) ? 0 : m_pre + 1;
      clr = (wr_en && addr == 5'h11) ? (wdata & 3) : 0;
      m_evt = (m_evt & ~clr) | (hit ? 2 : 0);
      if (wr_en) begin
        if (addr == 5'h00) begin
          if (on && (wdata & 1) == 0) m_ref = 0;
          m_mode = wdata;
        end else if (addr == 5'h04) m_ref = wdata;
        else if (addr == 5'h08) m_cap = wdata;
      end
      m_cnt = nxt_cnt;
      m_pre = nxt_pre;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 read map (model)", rdata, model_read(addr));
      check("R7 irq level (model)", irq, ((m_mode & 16) != 0 && (m_evt & 2) != 0) ? 1 : 0);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    addr = a; #1;
    v = rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(5'h00, v); check("R1 mode reset", v, 0);
    rd(5'h04, v); check("R1 ref reset", v, 0);
    rd(5'h08, v); check("R1 cap reset", v, 0);
    rd(5'h0C, v); check("R1 cnt reset", v, 0);
    rd(5'h11, v); check("R1 evt reset", v, 0);
    check("R1 irq reset", irq, 0);

    // R2 map, capture storage, unmapped offsets
    wr(5'h08, 16'hBEEF);
    wr(5'h14, 16'h1234);
    rd(5'h14, v); check("R2 unmapped reads zero", v, 0);
    rd(5'h08, v); check("R2 capture stored", v, 'hBEEF);

    // R10 count write ignored while disabled
    wr(5'h0C, 16'h0055);
    rd(5'h0C, v); check("R10 disabled load ignored", v, 0);

    // R3 source 1, P=2 -> advance every 3 clocks
    wr(5'h04, 16'hFFFF);
    wr(5'h00, 16'h0203);
    idle(30);
    rd(5'h0C, v); check("R3 divide by P+1", v, 10);

    // R11 count load
    wr(5'h0C, 16'h0100);
    rd(5'h0C, v); check("R11 count load", v, 'h100);

    // R4 source 2, P=1 -> advance every 32 clocks
    wr(5'h00, 16'h0105);
    idle(64);
    rd(5'h0C, v); check("R4 slow divide", v, 2);

    // R5 sources 0 and 3 do not count
    wr(5'h00, 16'h0001);
    idle(20);
    rd(5'h0C, v); check("R5 source 0 holds", v, 0);
    wr(5'h00, 16'h0007);
    idle(20);
    rd(5'h0C, v); check("R5 source 3 holds", v, 0);

    // R6 hit with restart, R7 irq
    wr(5'h04, 16'h0003);
    wr(5'h00, 16'h001B);
    idle(3);
    check("R7 irq before hit", irq, 0);
    idle(1);
    check("R7 irq after hit", irq, 1);
    rd(5'h0C, v); check("R6 restart to zero", v, 0);
    rd(5'h11, v); check("R6 ref event set", v, 2);

    // R8 write-one-to-clear
    wr(5'h11, 16'h0001);
    rd(5'h11, v); check("R8 bit0 clear keeps bit1", v, 2);
    wr(5'h04, 16'h0040);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); check("R8 bit1 cleared", v, 0);
    check("R7 irq low after clear", irq, 0);

    // R6 hit without restart keeps counting
    wr(5'h04, 16'h0002);
    wr(5'h00, 16'h0013);
    idle(4);
    rd(5'h0C, v); check("R6 continue past ref", v, 4);
    rd(5'h11, v); check("R6 event without restart", v, 2);

    // R7 interrupt enable gates irq
    wr(5'h00, 16'h0003);
    check("R7 irq masked", irq, 0);
    rd(5'h11, v); check("R7 event kept when masked", v, 2);

    // R8 hit and clear in the same cycle: set wins
    wr(5'h04, 16'h0000);
    wr(5'h00, 16'h001B);
    idle(2);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); check("R8 set beats clear", v, 2);

    // R9 disabling clears reference; R10 hold at zero
    wr(5'h00, 16'h0000);
    rd(5'h04, v); check("R9 ref cleared on disable", v, 0);
    rd(5'h0C, v); check("R10 count zero when off", v, 0);
    idle(10);
    rd(5'h0C, v); check("R10 count stays zero", v, 0);
    wr(5'h11, 16'h0003);

    // R9 enabling keeps reference
    wr(5'h04, 16'h0007);
    wr(5'h00, 16'h0003);
    rd(5'h04, v); check("R9 ref kept on enable", v, 7);

    // R12 reference write restarts
    idle(10);
    rd(5'h0C, v); check("R3 count with P=0", v, 10);
    wr(5'h04, 16'h0020);
    rd(5'h0C, v); check("R12 restart on ref write", v, 0);

    // random phase, compared against the model every clock
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: wr(5'h00, 16'((($urandom % 3) << 8) | ($urandom & 'hFF)));
        1: wr(5'h04, 16'($urandom % 8));
        2: wr(5'h0C, 16'($urandom % 8));
        3: wr(5'h11, 16'($urandom % 4));
        4: wr(5'h08, 16'($urandom));
        default: idle(1);
      endcase
      case ($urandom % 5)
        0: addr = 5'h00;
        1: addr = 5'h04;
        2: addr = 5'h0C;
        3: addr = 5'h11;
        default: addr = 5'h08;
      endcase
      idle($urandom % 4);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule